// File: doc/BRIEF.md
# Triggered Hit Capture Pipeline

This block sits behind a bank of channel discriminators and turns their binary outputs into time-stamped records. On every clock tick (one tick per sample period) it looks at a 64-bit hit vector and keeps a free-running timestamp. Each record it stores pairs a hit vector with the timestamp of the tick that vector belongs to. A small first-in first-out record buffer holds the records until a downstream serializer collects them.

Two capture policies exist. In self-trigger mode, any tick with at least one hit bit is stored at once. In external-trigger mode, every tick enters a fixed-length delay line. A trigger that arrives late picks up the vector that entered that line a fixed number of ticks earlier, together with that vector's own timestamp. Empty vectors are never stored. A combinational OR of the current hit bits is available at all times as a fast trigger source. When the buffer has no room, the record is lost, and the next record that is stored carries a flag reporting the loss. A timestamp clear input lets many copies of the block count in step.

Top module: `hitcap_top`

## Requirements
- R1: During and straight after reset the buffer is empty (`rec_valid_o` low), the timestamp is zero and the block is in self-trigger mode.
- R2: The timestamp rises by one on every clock edge and wraps from its all-ones value to zero (modulo 2^TS_W).
- R3: When `ts_sync_i` is high at a clock edge, the timestamp becomes zero at that edge. The tick presented during the sync cycle still carries its old timestamp.
- R4: In self-trigger mode, a tick with a nonzero hit vector is stored as one record. That record holds the vector and the timestamp current during that tick.
- R5: In external-trigger mode, `trig_i` high during tick t stores the vector and timestamp presented during tick t-PIPE_DEPTH (20 by default). A trigger whose delayed slot holds no vector loaded in external mode stores nothing. Without a trigger, nothing is stored.
- R6: A tick whose hit vector is all zero is never stored, in either mode.
- R7: The buffer holds at most FIFO_DEPTH (7) records and returns them in arrival order. `pop_i` removes the head record at the clock edge. `pop_i` on an empty buffer has no effect.
- R8: A capture that finds the buffer full (count at FIFO_DEPTH before the edge, even if a pop happens in the same cycle) is dropped and sets an overflow flag. The next stored record carries that flag in `rec_ovf_o` = 1, and storing that record clears the flag.
- R9: `prompt_or_o` equals the OR of all bits of `hits_i` in the same cycle.
- R10: A change of `mode_ext_i` takes effect at the first clock edge at which the delay line holds no slot loaded in external mode. The delay line loads new slots only while both the active mode and the requested mode are external. Until the change takes effect, the old mode stays in force.
- R11: `rec_valid_o` is high exactly when the buffer holds at least one record, and `rec_ts_o`, `rec_hits_o` and `rec_ovf_o` then show the oldest record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, one sample per edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| ts_sync_i | input | 1 | Clears the timestamp at the next edge |
| hits_i | input | HIT_W | Discriminator hit vector for the current tick |
| trig_i | input | 1 | External trigger, used in external-trigger mode |
| mode_ext_i | input | 1 | Requested mode: 1 external trigger, 0 self trigger |
| pop_i | input | 1 | Removes the head record |
| prompt_or_o | output | 1 | OR of all current hit bits |
| rec_valid_o | output | 1 | Buffer holds at least one record |
| rec_ts_o | output | TS_W | Timestamp of the head record |
| rec_hits_o | output | HIT_W | Hit vector of the head record |
| rec_ovf_o | output | 1 | Head record follows at least one dropped capture |

## Verification
Self-trigger capture is driven with single-bit, all-ones and alternating vectors mixed with empty ticks. This shows that storage depends on any bit being set and not on a particular bit, and that empty ticks leave nothing behind. External capture is driven with a vector that changes on every tick, so each record's hit pattern and timestamp name exactly which tick the trigger recovered. A wrong delay length therefore shows up as a mismatch. Bursts without pops fill the buffer past its depth to expose the drop rule and the one-shot overflow flag. Mode flips with a loaded delay line, and a long random mix of hits, triggers and pops, check the deferred mode change and the timestamp wrap.

// File: rtl/hitcap_pkg.sv
package hitcap_pkg;

  typedef enum logic {
    MODE_SELF = 1'b0,
    MODE_EXT  = 1'b1
  } cap_mode_e;

  // Increment with wrap back to zero when the limit is reached.
  function automatic logic [31:0] wrap_inc(input logic [31:0] val, input logic [31:0] lim);
    logic [31:0] nxt;
    nxt = val + 32'd1;
    return (nxt >= lim) ? 32'd0 : nxt;
  endfunction

  // Requested mode from the raw select pin.
  function automatic cap_mode_e mode_from_pin(input logic ext);
    return ext ? MODE_EXT : MODE_SELF;
  endfunction

endpackage

// File: rtl/hitcap_tstamp.sv
module hitcap_tstamp
  import hitcap_pkg::*;
#(
  parameter int TS_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_i,
  output logic [TS_W-1:0] ts_o
);

  localparam logic [31:0] TS_LIM = (TS_W >= 32) ? 32'hFFFF_FFFF : 32'(64'(1) << TS_W);

  logic [TS_W-1:0] ts_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ts_q <= '0;
    end else if (sync_i) begin
      ts_q <= '0;
    end else begin
      ts_q <= TS_W'(wrap_inc(32'(ts_q), TS_LIM));
    end
  end

  assign ts_o = ts_q;

  AST_TS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(sync_i)) |-> (TS_W'(ts_q - $past(ts_q)) == TS_W'(1))); // R2

  AST_TS_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(sync_i)) |-> (ts_q == '0)); // R3

endmodule

// File: rtl/hitcap_delay.sv
module hitcap_delay #(
  parameter int DEPTH = 20,
  parameter int W     = 88
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  output logic         busy_o
);

  logic [DEPTH-1:0] vld_q;
  logic [W-1:0]     dat_q [DEPTH];

  // Slot valid bits carry reset; data follows without one.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      vld_q <= {vld_q[DEPTH-2:0], in_valid_i};
    end
  end

  always_ff @(posedge clk_i) begin
    dat_q[0] <= in_data_i;
    for (int s = 1; s < DEPTH; s++) begin
      dat_q[s] <= dat_q[s-1];
    end
  end

  assign out_valid_o = vld_q[DEPTH-1];
  assign out_data_o  = dat_q[DEPTH-1];
  assign busy_o      = |vld_q;

  AST_DRAIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !in_valid_i) |=> !out_valid_o); // R10

endmodule

// File: rtl/hitcap_fifo.sv
module hitcap_fifo
  import hitcap_pkg::*;
#(
  parameter int DEPTH = 7,
  parameter int W     = 89
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_req_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         pop_i,
  output logic [W-1:0] rd_data_o,
  output logic         not_empty_o,
  output logic         wr_ok_o,
  output logic         drop_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_ptr_q, wr_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          full, pop_ok;

  assign full        = (cnt_q == FULL_CNT);
  assign wr_ok_o     = wr_req_i && !full;
  assign drop_o      = wr_req_i && full;
  assign pop_ok      = pop_i && (cnt_q != '0);
  assign not_empty_o = (cnt_q != '0);
  assign rd_data_o   = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_ok_o) wr_ptr_q <= PW'(wrap_inc(32'(wr_ptr_q), 32'(DEPTH)));
      if (pop_ok)  rd_ptr_q <= PW'(wrap_inc(32'(rd_ptr_q), 32'(DEPTH)));
      case ({wr_ok_o, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok_o) mem_q[wr_ptr_q] <= wr_data_i;
  end

  AST_FIFO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT); // R7

  AST_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!not_empty_o && pop_i && !wr_req_i) |=> !not_empty_o); // R7

  AST_WRITE_SHOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |=> not_empty_o); // R11

endmodule

// File: rtl/hitcap_top.sv
module hitcap_top
  import hitcap_pkg::*;
#(
  parameter int HIT_W      = 64,
  parameter int TS_W       = 24,
  parameter int PIPE_DEPTH = 20,
  parameter int FIFO_DEPTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ts_sync_i,
  input  logic [HIT_W-1:0] hits_i,
  input  logic             trig_i,
  input  logic             mode_ext_i,
  input  logic             pop_i,
  output logic             prompt_or_o,
  output logic             rec_valid_o,
  output logic [TS_W-1:0]  rec_ts_o,
  output logic [HIT_W-1:0] rec_hits_o,
  output logic             rec_ovf_o
);

  localparam int SLICE_W = TS_W + HIT_W;
  localparam int REC_W   = 1 + SLICE_W;

  cap_mode_e          mode_q, mode_req;
  logic [TS_W-1:0]    ts_now;
  logic               pipe_load, pipe_vld, pipe_busy;
  logic [SLICE_W-1:0] pipe_tail, cap_slice;
  logic [HIT_W-1:0]   tail_hits;
  logic               cap_req, fifo_wr_ok, fifo_drop, ovf_q;
  logic [REC_W-1:0]   fifo_rd;

  assign mode_req    = mode_from_pin(mode_ext_i);
  assign prompt_or_o = |hits_i;

  hitcap_tstamp #(.TS_W(TS_W)) u_tstamp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (ts_sync_i),
    .ts_o   (ts_now)
  );

  // Slots enter the delay line only while external mode is both active and requested.
  assign pipe_load = (mode_q == MODE_EXT) && (mode_req == MODE_EXT);

  hitcap_delay #(.DEPTH(PIPE_DEPTH), .W(SLICE_W)) u_delay (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (pipe_load),
    .in_data_i   ({ts_now, hits_i}),
    .out_valid_o (pipe_vld),
    .out_data_o  (pipe_tail),
    .busy_o      (pipe_busy)
  );

  assign tail_hits = pipe_tail[HIT_W-1:0];

  always_comb begin
    if (mode_q == MODE_SELF) begin
      cap_req   = |hits_i;
      cap_slice = {ts_now, hits_i};
    end else begin
      cap_req   = trig_i && pipe_vld && (|tail_hits);
      cap_slice = pipe_tail;
    end
  end

  hitcap_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (cap_req),
    .wr_data_i   ({ovf_q, cap_slice}),
    .pop_i       (pop_i),
    .rd_data_o   (fifo_rd),
    .not_empty_o (rec_valid_o),
    .wr_ok_o     (fifo_wr_ok),
    .drop_o      (fifo_drop)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      mode_q <= MODE_SELF;
    end else begin
      if (fifo_wr_ok)     ovf_q <= 1'b0;
      else if (fifo_drop) ovf_q <= 1'b1;
      if ((mode_req != mode_q) && !pipe_busy) mode_q <= mode_req;
    end
  end

  assign {rec_ovf_o, rec_ts_o, rec_hits_o} = fifo_rd;

  AST_SELF_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MODE_SELF) && (|hits_i) && !rec_valid_o) |=> rec_valid_o); // R4

  AST_EXT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q == MODE_EXT) && !trig_i && !rec_valid_o) |=> !rec_valid_o); // R5

  AST_DROP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_drop |=> ovf_q); // R8

  AST_OVF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_ok |=> !ovf_q); // R8

  AST_MODE_FLUSHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && (mode_q != $past(mode_q))) |-> !$past(pipe_busy)); // R10

endmodule

// File: tb/hitcap_top_tb_top.sv
module hitcap_top_tb_top;

  localparam int HW = 64;
  localparam int TW = 8;
  localparam int PD = 20;
  localparam int FD = 7;

  typedef struct {
    logic          ovf;
    logic [TW-1:0] ts;
    logic [HW-1:0] hits;
    string         tag;
  } exp_rec_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ts_sync = 1'b0;
  logic [HW-1:0] hits = '0;
  logic          trig = 1'b0;
  logic          mode_ext = 1'b0;
  logic          pop = 1'b0;
  logic          prompt_or, rec_valid, rec_ovf;
  logic [TW-1:0] rec_ts;
  logic [HW-1:0] rec_hits;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_en   = 0;
  bit done     = 0;

  // Reference state, advanced by the driver for each upcoming edge.
  exp_rec_t      exp_q[$];
  logic [TW-1:0] m_ts = '0;
  bit            m_ext = 0;
  bit            m_ovf = 0;
  int            m_cnt = 0;
  bit            m_pv [PD];
  logic [TW-1:0] m_pts [PD];
  logic [HW-1:0] m_phit [PD];
  string         phase_tag = "R4";

  always #10 clk = ~clk;

  hitcap_top #(.HIT_W(HW), .TS_W(TW), .PIPE_DEPTH(PD), .FIFO_DEPTH(FD)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ts_sync_i   (ts_sync),
    .hits_i      (hits),
    .trig_i      (trig),
    .mode_ext_i  (mode_ext),
    .pop_i       (pop),
    .prompt_or_o (prompt_or),
    .rec_valid_o (rec_valid),
    .rec_ts_o    (rec_ts),
    .rec_hits_o  (rec_hits),
    .rec_ovf_o   (rec_ovf)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: apply one tick of stimulus and push what the edge must produce.
  task automatic step(input logic [HW-1:0] h, input bit t, input bit p, input bit sy, input bit me);
    bit            cap, full_pre, any_v;
    logic [TW-1:0] cts;
    logic [HW-1:0] chit;
    exp_rec_t      e;
    @(negedge clk);
    rst_n = 1'b1; hits = h; trig = t; pop = p; ts_sync = sy; mode_ext = me;
    mon_en = 1;
    if (!m_ext) begin
      cap = (h != '0); cts = m_ts; chit = h;
    end else begin
      cap = t && m_pv[PD-1] && (m_phit[PD-1] != '0);
      cts = m_pts[PD-1]; chit = m_phit[PD-1];
    end
    full_pre = (m_cnt == FD);
    if (p && m_cnt > 0) begin
      void'(exp_q.pop_front());
      m_cnt--;
    end
    if (cap && !full_pre) begin
      e.ovf = m_ovf; e.ts = cts; e.hits = chit;
      e.tag = m_ovf ? "R8" : phase_tag;
      exp_q.push_back(e);
      m_cnt++;
      m_ovf = 0;
    end else if (cap) begin
      m_ovf = 1;
    end
    any_v = 0;
    for (int i = 0; i < PD; i++) any_v |= m_pv[i];
    for (int i = PD - 1; i > 0; i--) begin
      m_pv[i] = m_pv[i-1]; m_pts[i] = m_pts[i-1]; m_phit[i] = m_phit[i-1];
    end
    m_pv[0] = m_ext && me; m_pts[0] = m_ts; m_phit[0] = h;
    if ((me != m_ext) && !any_v) m_ext = me;
    m_ts = sy ? '0 : m_ts + TW'(1);
  endtask

  // Monitor: compares the design's head record with the scoreboard after each edge.
  always @(posedge clk) begin
    #5;
    if (mon_en && !done) begin
      check(rec_valid == (m_cnt != 0), "R11 valid", 128'(rec_valid), 128'(m_cnt != 0));
      check(prompt_or == (hits != '0), "R9 prompt", 128'(prompt_or), 128'(hits != '0));
      if (m_cnt != 0 && exp_q.size() != 0) begin
        check({rec_ovf, rec_ts, rec_hits} == {exp_q[0].ovf, exp_q[0].ts, exp_q[0].hits},
              exp_q[0].tag, {rec_ovf, rec_ts, rec_hits},
              {exp_q[0].ovf, exp_q[0].ts, exp_q[0].hits});
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [HW-1:0] h;
    for (int i = 0; i < PD; i++) begin m_pv[i] = 0; m_pts[i] = '0; m_phit[i] = '0; end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(rec_valid == 1'b0, "R1 empty after reset", 128'(rec_valid), 128'(0));
    check(prompt_or == 1'b0, "R1 prompt idle", 128'(prompt_or), 128'(0));

    // R4/R6/R9: self trigger with distinct patterns and empty ticks
    phase_tag = "R4";
    step(64'h1, 0, 0, 0, 0);
    step('0, 0, 0, 0, 0);
    step({HW{1'b1}}, 0, 0, 0, 0);
    step('0, 1, 0, 0, 0);
    step({32{2'b10}}, 0, 0, 0, 0);
    step(64'h8000_0000_0000_0000, 0, 0, 0, 0);
    repeat (6) step('0, 0, 1, 0, 0);
    // R7: pops on an empty buffer change nothing
    repeat (3) step('0, 0, 1, 0, 0);
    check(rec_valid == 1'b0, "R7 pop on empty", 128'(rec_valid), 128'(0));

    // R8: overflow, drop and one-shot flag
    for (int i = 0; i < 10; i++) step(64'(i + 1) << i, 0, 0, 0, 0);
    check(m_cnt == FD, "R7 buffer depth", 128'(m_cnt), 128'(FD));
    step(64'h55, 0, 1, 0, 0);
    step(64'h77, 0, 1, 0, 0);
    repeat (9) step('0, 0, 1, 0, 0);

    // R3: timestamp clear
    phase_tag = "R3";
    step(64'h3, 0, 0, 1, 0);
    step(64'h4, 0, 0, 0, 0);
    step(64'h5, 0, 1, 0, 0);
    repeat (3) step('0, 0, 1, 0, 0);

    // R2: long run through a timestamp wrap
    phase_tag = "R2";
    for (int i = 0; i < 600; i++) begin
      h = (i % 37 == 0) ? 64'(i * 7 + 1) : '0;
      step(h, 0, (i % 5 == 0), 0, 0);
    end
    repeat (8) step('0, 0, 1, 0, 0);

    // R5: external trigger with a tick-unique pattern
    phase_tag = "R5";
    for (int i = 0; i < 60; i++) begin
      h = (i % 9 == 4) ? '0 : {32'(i) ^ 32'hA5A5_0000, 32'(i * 3 + 1)};
      step(h, (i == 3) || (i % 7 == 2) || (i == 22) || (i == 24), (i % 4 == 0), 0, 1);
    end
    repeat (8) step('0, 0, 1, 0, 1);

    // R10: switch back to self with a loaded delay line
    phase_tag = "R10";
    for (int i = 0; i < 30; i++) step(64'(i + 100), 0, 0, 0, 1);
    for (int i = 0; i < 30; i++) step(64'(i + 200), (i == 5), (i % 2 == 0), 0, 0);
    repeat (10) step('0, 0, 1, 0, 0);

    // Random mix of all inputs
    phase_tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      bit me;
      me = ((i / 170) % 2) == 1;
      phase_tag = me ? "R5" : "R4";
      h = ($urandom % 4 == 0) ? {$urandom, $urandom} : '0;
      step(h, ($urandom % 6 == 0), ($urandom % 3 == 0), ($urandom % 500 == 0), me);
    end
    repeat (12) step('0, 0, 1, 0, 0);
    @(negedge clk);
    check(rec_valid == 1'b0, "R7 drained", 128'(rec_valid), 128'(0));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule